// File: doc/BRIEF.md
# SPI Channel Status and Interrupt Controller

This block keeps the status, interrupt-enable, FIFO-threshold and FIFO-word-count registers of one SPI channel and drives one level-sensitive interrupt line. The transfer engine supplies one-cycle event pulses (transfer finished, transmit underflow, receive overflow) and a level that is high while a transfer is in flight. The two 8-word data FIFOs supply their occupancy counts. Events and threshold crossings are latched into sticky status bits. Software clears a bit by writing 1 to it.

Software reaches the registers through a simple port: a write strobe, a byte offset, write data, and read data that follows the offset combinationally. The interrupt output is high while any latched status bit has its enable set. The enable register orders its bits differently from the status register.

Top module: `spi_stat_irq`

## Requirements
- R1: After reset the status, enable and threshold registers read 0 and `irq` is low, provided `xfer_busy` is low and both FIFO levels are 0.
- R2: Status bit 0 (pending) always equals `xfer_busy`. Writing to the status register does not change it. Status bits 31:6 read 0.
- R3: A pulse on `evt_done`, `evt_tx_under` or `evt_rx_over` sets status bit 1, 4 or 5 respectively on the next clock edge. The bit then stays set.
- R4: A write to the status register (offset 0x0C) clears each sticky bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: If a setting condition and a write-1 clear reach the same bit in the same cycle, the bit stays set.
- R6: Status bit 2 (transmit threshold) is set in every cycle where `tx_level` is below the transmit threshold, which is held in threshold-register bits 7:4.
- R7: Status bit 3 (receive threshold) is set in every cycle where `rx_level` is above the receive threshold, which is held in threshold-register bits 3:0.
- R8: The enable register (offset 0x10, bits 4:0) maps done to bit 0, transmit threshold to bit 1, receive threshold to bit 2, transmit underflow to bit 3 and receive overflow to bit 4. `irq` is the OR of each status bit ANDed with its enable bit.
- R9: The pending bit never drives `irq`, whatever the enables are.
- R10: The word-count register (offset 0x18) reads `rx_level` in bits 3:0 and `tx_level` in bits 7:4.
- R11: The threshold register sits at offset 0x14 (bits 7:0, read/write). Any other offset reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| xfer_busy | input | 1 | Transfer in flight |
| evt_done | input | 1 | Transfer-finished pulse |
| evt_tx_under | input | 1 | Transmit underflow pulse |
| evt_rx_over | input | 1 | Receive overflow pulse |
| tx_level | input | 4 | Transmit FIFO occupancy (0 to 8) |
| rx_level | input | 4 | Receive FIFO occupancy (0 to 8) |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a write-1 clear that lands in the same cycle as a new event on the same bit. The bench drives `evt_done` high on the same falling edge that presents the status write. Both are sampled on one rising edge, and the bench then expects the bit to read as set. The threshold bits are also awkward because they are sticky. The bench first moves the FIFO level back inside the threshold, then clears the bit, and checks that it stays clear. That separates "the condition held" from "the bit was latched".

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  // register byte offsets
  localparam logic [7:0] OFF_STAT = 8'h0C;
  localparam logic [7:0] OFF_EN   = 8'h10;
  localparam logic [7:0] OFF_THR  = 8'h14;
  localparam logic [7:0] OFF_WC   = 8'h18;

  // status bit positions
  localparam int ST_PEND = 0;
  localparam int ST_DONE = 1;
  localparam int ST_TXTH = 2;
  localparam int ST_RXTH = 3;
  localparam int ST_TXUF = 4;
  localparam int ST_RXOF = 5;
  localparam int ST_W    = 6;
  localparam int EN_W    = ST_W - 1;

  // enable bit k guards status bit k+1
  function automatic logic [ST_W-1:0] en_to_stat(input logic [EN_W-1:0] en);
    return {en, 1'b0};
  endfunction

  function automatic logic tx_below(input logic [3:0] lvl, input logic [3:0] thr);
    return lvl < thr;
  endfunction

  function automatic logic rx_above(input logic [3:0] lvl, input logic [3:0] thr);
    return lvl > thr;
  endfunction
endpackage

// File: rtl/spi_stat_sticky.sv
module spi_stat_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_o[i]);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o[i] && !clr_i[i]) |=> q_o[i]);
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
  end
endmodule

// File: rtl/spi_lvl_cmp.sv
module spi_lvl_cmp #(
  parameter int LVL_W = 4
) (
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  output logic             tx_hit_o,
  output logic             rx_hit_o
);
  import spi_stat_pkg::*;
  always_comb begin
    tx_hit_o = tx_below(4'(tx_level_i), 4'(tx_thr_i));
    rx_hit_o = rx_above(4'(rx_level_i), 4'(rx_thr_i));
  end
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
  import spi_stat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] stat_i,
  input  logic [EN_W-1:0] en_i,
  output logic            irq_o
);
  logic [ST_W-1:0] gate;
  always_comb begin
    gate  = en_to_stat(en_i);
    irq_o = |(stat_i & gate);
  end

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_i[ST_W-1:1] == '0) |-> !irq_o);
  assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |-> !irq_o);
endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq
  import spi_stat_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             xfer_busy,
  input  logic             evt_done,
  input  logic             evt_tx_under,
  input  logic             evt_rx_over,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  output logic             irq
);
  localparam int THR_W = 2 * LVL_W;
  localparam int NS    = ST_W - 1;

  logic            sel_stat, sel_en, sel_thr, sel_wc;
  logic            wr_stat, wr_en, wr_thr;
  logic [EN_W-1:0] en_q;
  logic [THR_W-1:0] thr_q;
  logic            tx_hit, rx_hit;
  logic [NS-1:0]   sticky_set, sticky_clr, sticky_q;
  logic [ST_W-1:0] stat_word;

  always_comb begin
    sel_stat = reg_addr == AW'(OFF_STAT);
    sel_en   = reg_addr == AW'(OFF_EN);
    sel_thr  = reg_addr == AW'(OFF_THR);
    sel_wc   = reg_addr == AW'(OFF_WC);
    wr_stat  = reg_wr && sel_stat;
    wr_en    = reg_wr && sel_en;
    wr_thr   = reg_wr && sel_thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      thr_q <= '0;
    end else begin
      if (wr_en)  en_q  <= reg_wdata[EN_W-1:0];
      if (wr_thr) thr_q <= reg_wdata[THR_W-1:0];
    end
  end

  spi_lvl_cmp #(.LVL_W(LVL_W)) u_cmp (
    .tx_level_i (tx_level),
    .rx_level_i (rx_level),
    .tx_thr_i   (thr_q[THR_W-1:LVL_W]),
    .rx_thr_i   (thr_q[LVL_W-1:0]),
    .tx_hit_o   (tx_hit),
    .rx_hit_o   (rx_hit)
  );

  // sticky vector index k holds status bit k+1
  always_comb begin
    sticky_set = '0;
    sticky_set[ST_DONE-1] = evt_done;
    sticky_set[ST_TXTH-1] = tx_hit;
    sticky_set[ST_RXTH-1] = rx_hit;
    sticky_set[ST_TXUF-1] = evt_tx_under;
    sticky_set[ST_RXOF-1] = evt_rx_over;
    sticky_clr = wr_stat ? reg_wdata[ST_W-1:1] : '0;
  end

  spi_stat_sticky #(.N(NS)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sticky_set),
    .clr_i (sticky_clr),
    .q_o   (sticky_q)
  );

  assign stat_word = {sticky_q, xfer_busy};

  spi_irq_mask u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_i (stat_word),
    .en_i   (en_q),
    .irq_o  (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_stat)     reg_rdata[ST_W-1:0]  = stat_word;
    else if (sel_en)  reg_rdata[EN_W-1:0]  = en_q;
    else if (sel_thr) reg_rdata[THR_W-1:0] = thr_q;
    else if (sel_wc)  reg_rdata[THR_W-1:0] = {tx_level, rx_level};
  end

  assert_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stat |-> (reg_rdata[ST_PEND] == xfer_busy && reg_rdata[DW-1:ST_W] == '0));
  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_stat || sel_en || sel_thr || sel_wc) |-> reg_rdata == '0);
  assert_en_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
  assert_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_over |=> sticky_q[ST_RXOF-1]);
endmodule

// File: tb/tb_spi_stat_irq.sv
`timescale 1ns/1ps
module tb_spi_stat_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_busy = 1'b0;
  logic        evt_done = 1'b0, evt_tx_under = 1'b0, evt_rx_over = 1'b0;
  logic [3:0]  tx_level = 4'd0, rx_level = 4'd0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  localparam logic [7:0] A_ST = 8'h0C, A_EN = 8'h10, A_TH = 8'h14, A_WC = 8'h18;

  always #2.5 clk = ~clk;

  spi_stat_irq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_busy(xfer_busy),
    .evt_done(evt_done), .evt_tx_under(evt_tx_under), .evt_rx_over(evt_rx_over),
    .tx_level(tx_level), .rx_level(rx_level), .irq(irq)
  );

  // monitor: compares results one time unit after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = it.is_irq ? {31'b0, irq} : reg_rdata;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    sb.push_back('{1'b0, a, e, tag});
  endtask

  task automatic exp_irq(input logic e, input string tag);
    @(negedge clk);
    sb.push_back('{1'b1, 8'h00, {31'b0, e}, tag});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evt_done = 1'b1;
      1: evt_tx_under = 1'b1;
      default: evt_rx_over = 1'b1;
    endcase
    @(negedge clk);
    evt_done = 1'b0; evt_tx_under = 1'b0; evt_rx_over = 1'b0;
  endtask

  task automatic set_lvl(input logic [3:0] t, input logic [3:0] r);
    @(negedge clk);
    tx_level = t; rx_level = r;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    exp_rd(A_ST, 32'h0, "R1 status");
    exp_rd(A_EN, 32'h0, "R1 enable");
    exp_rd(A_TH, 32'h0, "R1 threshold");
    exp_irq(1'b0, "R1 irq");

    // R11 map and unmapped offsets
    wr(A_EN, 32'hFFFF_FFFF);
    exp_rd(A_EN, 32'h1F, "R11 enable rw");
    wr(A_EN, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    exp_rd(8'h04, 32'h0, "R11 unmapped reads 0");
    exp_rd(A_EN, 32'h0, "R11 unmapped write no effect");
    exp_rd(A_ST, 32'h0, "R11 status untouched");
    wr(A_TH, 32'h0000_0180);
    exp_rd(A_TH, 32'h80, "R11 threshold rw");
    exp_rd(A_ST, 32'h04, "R6 tx 0 below thr 8");
    wr(A_TH, 32'h0);
    wr(A_ST, 32'h04);
    exp_rd(A_ST, 32'h0, "R4 tx-threshold cleared");

    // R2 pending
    @(negedge clk); xfer_busy = 1'b1;
    exp_rd(A_ST, 32'h01, "R2 pending follows busy");
    wr(A_ST, 32'hFFFF_FFFF);
    exp_rd(A_ST, 32'h01, "R2 pending not cleared");
    @(negedge clk); xfer_busy = 1'b0;
    exp_rd(A_ST, 32'h0, "R2 pending drops");

    // R3 events
    pulse(0);
    exp_rd(A_ST, 32'h02, "R3 done");
    pulse(1);
    exp_rd(A_ST, 32'h12, "R3 tx underflow");
    pulse(2);
    exp_rd(A_ST, 32'h32, "R3 rx overflow");

    // R4 selective clear
    wr(A_ST, 32'h10);
    exp_rd(A_ST, 32'h22, "R4 partial clear");
    wr(A_ST, 32'h22);
    exp_rd(A_ST, 32'h0, "R4 full clear");

    // R5 event wins over same-cycle clear
    @(negedge clk);
    evt_done = 1'b1; reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h02;
    @(negedge clk);
    evt_done = 1'b0; reg_wr = 1'b0;
    exp_rd(A_ST, 32'h02, "R5 event wins");
    wr(A_ST, 32'h02);
    exp_rd(A_ST, 32'h0, "R5 later clear");

    // R6 transmit threshold
    set_lvl(4'd3, 4'd0);
    wr(A_TH, 32'h30);
    exp_rd(A_ST, 32'h0, "R6 tx equal not below");
    set_lvl(4'd2, 4'd0);
    exp_rd(A_ST, 32'h04, "R6 tx below");
    set_lvl(4'd3, 4'd0);
    exp_rd(A_ST, 32'h04, "R6 sticky after recover");
    wr(A_ST, 32'h04);
    exp_rd(A_ST, 32'h0, "R6 cleared stays clear");

    // R7 receive threshold
    wr(A_TH, 32'h32);
    set_lvl(4'd3, 4'd2);
    exp_rd(A_ST, 32'h0, "R7 rx equal not above");
    set_lvl(4'd3, 4'd3);
    exp_rd(A_ST, 32'h08, "R7 rx above");
    set_lvl(4'd3, 4'd0);
    wr(A_ST, 32'h08);
    exp_rd(A_ST, 32'h0, "R7 cleared");

    // R10 word count
    set_lvl(4'd7, 4'd2);
    exp_rd(A_WC, 32'h72, "R10 word count");
    set_lvl(4'd8, 4'd1);
    exp_rd(A_WC, 32'h81, "R10 word count full tx");
    exp_rd(A_ST, 32'h0, "R10 no threshold side effect");

    // R8 enable mapping
    wr(A_EN, 32'h01);
    pulse(1);
    exp_irq(1'b0, "R8 underflow masked by done enable");
    pulse(0);
    exp_irq(1'b1, "R8 done enable bit0");
    wr(A_ST, 32'h3E);
    exp_irq(1'b0, "R8 cleared irq low");
    wr(A_EN, 32'h08);
    pulse(1);
    exp_irq(1'b1, "R8 underflow enable bit3");
    wr(A_ST, 32'h3E);
    wr(A_EN, 32'h10);
    pulse(2);
    exp_irq(1'b1, "R8 overflow enable bit4");
    wr(A_ST, 32'h3E);
    exp_irq(1'b0, "R8 overflow cleared");
    wr(A_EN, 32'h02);
    set_lvl(4'd1, 4'd0);
    exp_irq(1'b1, "R8 tx threshold enable bit1");
    set_lvl(4'd7, 4'd0);
    wr(A_ST, 32'h3E);
    exp_irq(1'b0, "R8 tx threshold cleared");
    wr(A_EN, 32'h04);
    set_lvl(4'd7, 4'd3);
    exp_irq(1'b1, "R8 rx threshold enable bit2");
    set_lvl(4'd7, 4'd0);
    wr(A_ST, 32'h3E);
    exp_irq(1'b0, "R8 rx threshold cleared");

    // R9 pending never interrupts
    wr(A_EN, 32'h1F);
    @(negedge clk); xfer_busy = 1'b1;
    exp_rd(A_ST, 32'h01, "R9 only pending set");
    exp_irq(1'b0, "R9 pending no irq");
    @(negedge clk); xfer_busy = 1'b0;

    @(negedge clk);
    #2;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule